// File: doc/BRIEF.md
# Approximate Hybrid-Radix Signed Multiplier

This block multiplies two 16-bit two's complement operands, A and B, and returns a 32-bit signed result that is exact for A times a rounded copy of B. The rounding affects only the ten low bits of B. Those bits are read as one signed digit and snapped to zero or to a power of two between 64 and 512. The six upper bits of B are recoded exactly into three radix-4 Booth digits in {0, ±1, ±2}. This gives four partial products in total.

Each partial product is formed in one's complement with a correction bit. Sign extension uses a single compensation constant. Two levels of 4:2 compressors reduce the rows to a sum and a carry vector, and a carry-propagate adder combines them. The result is registered, so a product accepted with the valid strobe appears one clock later. The block suits error-tolerant datapaths such as filters, where the cost of the low-order digits matters more than their precision.

Top module: `hybrid_approx_mul`

## Requirements
- R1: When `in_valid` is high at a rising edge without reset, `product` after that edge equals the 32-bit two's complement value of A × B̃. B̃ is the approximated multiplier defined by R2 to R5.
- R2: Let L = −512·b9 + b[8:0] be the signed value of the ten low bits of B. Then B̃ = (B − L) + round(L), so the upper six bits contribute exactly. When b[9:0] is zero, the product is exactly A × B.
- R3: round(L) is always one of 0, ±64, ±128, ±256 or ±512. A nonzero result has the sign of L, and negative L rounds to the negative of the rounded magnitude.
- R4: When |L| < 32, round(L) is 0.
- R5: The magnitude rounds to the nearest of {64, 128, 256, 512}, and a tie goes to the larger value. This gives the bands 32–95 → 64, 96–191 → 128, 192–383 → 256 and 384–512 → 512.
- R6: The extreme operands are handled exactly, including A = −32768 and B = −32768, with no wraparound in the result.
- R7: `out_valid` after a rising edge equals `in_valid` at that edge, provided reset is low.
- R8: A synchronous active-high `rst` drives `out_valid` and `product` to 0 after the edge, even when `in_valid` is high.
- R9: While `in_valid` is low, `product` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are presented this cycle |
| a_in | input | 16 | Multiplicand A, two's complement |
| b_in | input | 16 | Multiplier B, two's complement, recoded approximately |
| out_valid | output | 1 | `product` holds a new result |
| product | output | 32 | A × B̃, two's complement |

## Verification
The bench sweeps all 1024 patterns of the ten low bits under random upper bits and operands. This covers every band edge, including the ties at 32, 96, 192 and 384, and the negative extreme −512.
- An encoder that rounds ties downward, or that places a band boundary off by one, gives a product off by a multiple of A at exactly those patterns.
- A design that takes the digit sign from the wrong bit gives a wrong sign on negative low groups.
- A broken sign-extension constant or correction bit shows up on negative Booth digits and on A = −32768, where the result has the wrong upper bits.

Reset during a valid cycle and idle cycles with changing operands confirm that the result register clears and holds as required.

// File: rtl/hamul_pkg.sv
package hamul_pkg;

    localparam int OP_W    = 16;                    // operand width
    localparam int LO_W    = 10;                    // bits folded into the approximate digit
    localparam int LO_SEL  = 4;                     // number of power-of-two choices
    localparam int N_BOOTH = (OP_W - LO_W) / 2;     // exact radix-4 digits
    localparam int N_PP    = N_BOOTH + 1;           // partial-product rows
    localparam int PROD_W  = 2 * OP_W;
    localparam int LO_PP_W = OP_W + LO_W;           // field width of the low row
    localparam int BO_PP_W = OP_W + 2;              // field width of a Booth row

    typedef struct packed {
        logic              neg;
        logic [LO_SEL-1:0] sel;   // one-hot: x(2^(LO_W-4)) .. x(2^(LO_W-1))
    } lo_dig_t;

    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_dig_t;

    typedef struct packed {
        logic              vld;
        logic [PROD_W-1:0] prod;
    } out_st_t;

    // Sum of all flipped sign-bit weights, negated modulo 2^PROD_W.
    function automatic logic [PROD_W-1:0] sext_const();
        logic [PROD_W-1:0] acc;
        acc = PROD_W'(1) << (LO_PP_W - 1);
        for (int i = 0; i < N_BOOTH; i++) begin
            acc = acc + (PROD_W'(1) << (BO_PP_W - 1 + LO_W + 2 * i));
        end
        return ~acc + 1'b1;
    endfunction

    localparam logic [PROD_W-1:0] SEXT_K = sext_const();

endpackage

// File: rtl/hamul_lo_enc.sv
module hamul_lo_enc
    import hamul_pkg::*;
(
    input  logic [LO_W-1:0] bits,
    output lo_dig_t         dig
);

    logic            neg_raw;
    logic [LO_W-1:0] mag;
    logic [LO_SEL-1:0] sel;

    // Lower edge of the band that rounds to choice j (ties go up).
    function automatic logic [LO_W:0] lo_bound(int j);
        if (j == 0)
            return (LO_W+1)'(1) << (LO_W - 5);
        else if (j >= LO_SEL)
            return (LO_W+1)'(1) << LO_W;
        else
            return (LO_W+1)'(3) << (LO_W - 6 + j);
    endfunction

    always_comb begin
        neg_raw = bits[LO_W-1];
        mag     = neg_raw ? (~bits + 1'b1) : bits;
        sel     = '0;
        for (int j = 0; j < LO_SEL; j++) begin
            if (({1'b0, mag} >= lo_bound(j)) && ({1'b0, mag} < lo_bound(j + 1)))
                sel[j] = 1'b1;
        end
        dig.sel = sel;
        dig.neg = neg_raw & (|sel);
    end

    // Checks on the encoder outputs
    always_comb begin
        p_sel_onehot_r3: assert ($onehot0(dig.sel));
        if (|dig.sel) begin
            p_sign_follows_r3: assert (dig.neg == bits[LO_W-1]);
        end
        if (!bits[LO_W-1] && (bits < LO_W'(32))) begin
            p_small_pos_zero_r4: assert (dig.sel == '0 && !dig.neg);
        end
        if (bits[LO_W-1] && (bits > LO_W'(-32))) begin
            p_small_neg_zero_r4: assert (dig.sel == '0 && !dig.neg);
        end
    end

endmodule

// File: rtl/hamul_booth_enc.sv
module hamul_booth_enc
    import hamul_pkg::*;
(
    input  logic [2:0] trip,
    output booth_dig_t dig
);

    always_comb begin
        dig.one = trip[0] ^ trip[1];
        dig.two = (trip == 3'b011) | (trip == 3'b100);
        dig.neg = trip[2] & ~(trip[1] & trip[0]);
    end

    always_comb begin
        p_booth_excl_r2: assert (!(dig.one && dig.two));
        if (trip == 3'b000 || trip == 3'b111) begin
            p_booth_zero_r2: assert (!dig.one && !dig.two && !dig.neg);
        end
    end

endmodule

// File: rtl/hamul_cmp42_row.sv
module hamul_cmp42_row #(
    parameter int W = 32
) (
    input  logic [W-1:0] in0,
    input  logic [W-1:0] in1,
    input  logic [W-1:0] in2,
    input  logic [W-1:0] in3,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);

    logic [W-1:0] chain;   // lateral carry into each bit cell

    assign chain[0]   = 1'b0;
    assign carry_o[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            if (g < W - 1) begin : g_full
                logic t;
                assign t            = in0[g] ^ in1[g] ^ in2[g];
                assign chain[g+1]   = (in0[g] & in1[g]) | (in0[g] & in2[g]) | (in1[g] & in2[g]);
                assign sum_o[g]     = t ^ in3[g] ^ chain[g];
                assign carry_o[g+1] = (t & in3[g]) | (t & chain[g]) | (in3[g] & chain[g]);
            end else begin : g_top
                assign sum_o[g] = in0[g] ^ in1[g] ^ in2[g] ^ in3[g] ^ chain[g];
            end
        end
    endgenerate

endmodule

// File: rtl/hybrid_approx_mul.sv
module hybrid_approx_mul
    import hamul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   a_in,
    input  logic [OP_W-1:0]   b_in,
    output logic              out_valid,
    output logic [PROD_W-1:0] product
);

    lo_dig_t           lo_dig;
    booth_dig_t        bo_dig [N_BOOTH];
    logic [LO_PP_W-1:0] a_lo;
    logic [BO_PP_W-1:0] a_bo;
    logic [PROD_W-1:0] pp_row [N_PP];
    logic [PROD_W-1:0] corr_row;
    logic [PROD_W-1:0] s1, c1, s2, c2, full_sum;
    out_st_t           st_d, st_q;

    assign a_lo = {{(LO_PP_W-OP_W){a_in[OP_W-1]}}, a_in};
    assign a_bo = {{(BO_PP_W-OP_W){a_in[OP_W-1]}}, a_in};

    hamul_lo_enc u_lo (
        .bits (b_in[LO_W-1:0]),
        .dig  (lo_dig)
    );

    genvar g;
    generate
        for (g = 0; g < N_BOOTH; g++) begin : g_booth
            logic [2:0] trip;
            assign trip = {b_in[LO_W+2*g+1], b_in[LO_W+2*g], b_in[LO_W+2*g-1]};
            hamul_booth_enc u_be (
                .trip (trip),
                .dig  (bo_dig[g])
            );
        end
    endgenerate

    // Partial-product rows: one's complement, flipped sign bit, correction row
    always_comb begin
        logic [LO_PP_W-1:0] lo_mult;
        logic [LO_PP_W-1:0] lo_field;
        logic [BO_PP_W-1:0] bo_mult;
        logic [BO_PP_W-1:0] bo_field;

        lo_mult = '0;
        for (int j = 0; j < LO_SEL; j++) begin
            if (lo_dig.sel[j])
                lo_mult = a_lo << (LO_W - LO_SEL + j);
        end
        lo_field = lo_dig.neg ? ~lo_mult : lo_mult;
        lo_field[LO_PP_W-1] = ~lo_field[LO_PP_W-1];
        pp_row[0] = PROD_W'(lo_field);

        corr_row    = '0;
        corr_row[0] = lo_dig.neg;

        for (int i = 0; i < N_BOOTH; i++) begin
            bo_mult = bo_dig[i].one ? a_bo : (bo_dig[i].two ? (a_bo << 1) : '0);
            bo_field = bo_dig[i].neg ? ~bo_mult : bo_mult;
            bo_field[BO_PP_W-1] = ~bo_field[BO_PP_W-1];
            pp_row[i+1] = PROD_W'(bo_field) << (LO_W + 2 * i);
            corr_row[LO_W + 2 * i] = bo_dig[i].neg;
        end
    end

    hamul_cmp42_row #(.W(PROD_W)) u_lvl1 (
        .in0     (pp_row[0]),
        .in1     (pp_row[1]),
        .in2     (pp_row[2]),
        .in3     (pp_row[3]),
        .sum_o   (s1),
        .carry_o (c1)
    );

    hamul_cmp42_row #(.W(PROD_W)) u_lvl2 (
        .in0     (s1),
        .in1     (c1),
        .in2     (corr_row),
        .in3     (SEXT_K),
        .sum_o   (s2),
        .carry_o (c2)
    );

    assign full_sum = s2 + c2;

    // Next state
    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.vld = in_valid;
            if (in_valid)
                st_d.prod = full_sum;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign product   = st_q.prod;

    // Output timing and value checks
    p_valid_lat_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!out_valid && product == '0));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(product));
    p_zero_a_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && a_in == '0) |=> product == '0);
    p_exact_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && b_in[LO_W-1:0] == '0) |=>
        $signed(product) == $signed($past(a_in)) * $signed($past(b_in)));

endmodule

// File: tb/sim_hybrid_approx_mul.sv
module sim_hybrid_approx_mul;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic        out_valid;
    logic [31:0] product;

    int    n_checks = 0;
    int    n_errors = 0;
    logic  have_exp = 1'b0;
    logic  exp_v    = 1'b0;
    logic [31:0] exp_p = '0;
    string p_tag    = "R8";
    string v_tag    = "R8";
    logic  finished = 1'b0;

    always #5 clk = ~clk;

    hybrid_approx_mul u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .a_in      (a_in),
        .b_in      (b_in),
        .out_valid (out_valid),
        .product   (product)
    );

    // Signed value of the ten low bits of B
    function automatic int low_val(logic [15:0] b);
        int lo;
        lo = int'(b[9:0]);
        if (lo >= 512) lo = lo - 1024;
        return lo;
    endfunction

    // Approximated multiplier per R2..R5
    function automatic int approx_b(logic [15:0] b);
        int bi, lo, m, r;
        bi = int'($signed(b));
        lo = low_val(b);
        m  = (lo < 0) ? -lo : lo;
        if (m < 32)       r = 0;
        else if (m < 96)  r = 64;
        else if (m < 192) r = 128;
        else if (m < 384) r = 256;
        else              r = 512;
        return (bi - lo) + ((lo < 0) ? -r : r);
    endfunction

    function automatic logic [31:0] ref_prod(logic [15:0] a, logic [15:0] b);
        longint p;
        p = longint'($signed(a)) * longint'(approx_b(b));
        return p[31:0];
    endfunction

    function automatic string low_tag(logic [15:0] b);
        int lo;
        lo = low_val(b);
        if (lo > -32 && lo < 32) return "R4";
        if (lo < 0) return "R3";
        return "R5";
    endfunction

    task automatic check_out();
        if (!have_exp) return;
        n_checks++;
        if (out_valid !== exp_v) begin
            n_errors++;
            $display("FAIL %s out_valid: got %0b expected %0b", v_tag, out_valid, exp_v);
        end
        n_checks++;
        if (product !== exp_p) begin
            n_errors++;
            $display("FAIL %s product: got %h expected %h (a=%h b=%h)", p_tag, product, exp_p, a_in, b_in);
        end
    endtask

    // Compare the previous cycle's result, then present new inputs
    task automatic step(input logic r, input logic v, input logic [15:0] a,
                        input logic [15:0] b, input string tag);
        @(negedge clk);
        check_out();
        rst = r; in_valid = v; a_in = a; b_in = b;
        if (r) begin
            exp_v = 1'b0; exp_p = '0; v_tag = "R8";
        end else begin
            exp_v = v; v_tag = "R7";
            if (v) exp_p = ref_prod(a, b);
        end
        p_tag = tag;
        have_exp = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        step(1'b1, 1'b0, 16'h0000, 16'h0000, "R8");
        step(1'b1, 1'b1, 16'h1234, 16'h5678, "R8");
        step(1'b1, 1'b0, 16'h0000, 16'h0000, "R8");

        // R2: low bits zero, upper digits exact
        for (int i = 0; i < 64; i++) begin
            step(1'b0, 1'b1, 16'($urandom), {6'(i), 10'd0}, "R2");
        end

        // R3/R4/R5: every low-group pattern, including ties and -512
        for (int lo = 0; lo < 1024; lo++) begin
            logic [15:0] b;
            b = {6'($urandom), 10'(lo)};
            step(1'b0, 1'b1, 16'($urandom), b, low_tag(b));
        end
        // Ties with A = 1 make the rounded digit visible directly (R5)
        step(1'b0, 1'b1, 16'd1, 16'd32,  "R5");
        step(1'b0, 1'b1, 16'd1, 16'd96,  "R5");
        step(1'b0, 1'b1, 16'd1, 16'd192, "R5");
        step(1'b0, 1'b1, 16'd1, 16'd384, "R5");
        step(1'b0, 1'b1, 16'd1, 16'h03A0, "R3");
        step(1'b0, 1'b1, 16'd1, 16'd31,  "R4");

        // R6: extreme operands
        step(1'b0, 1'b1, 16'h8000, 16'h8000, "R6");
        step(1'b0, 1'b1, 16'h8000, 16'h7FFF, "R6");
        step(1'b0, 1'b1, 16'h7FFF, 16'h8000, "R6");
        step(1'b0, 1'b1, 16'h7FFF, 16'h7FFF, "R6");
        step(1'b0, 1'b1, 16'h8000, 16'h8200, "R6");
        step(1'b0, 1'b1, 16'hFFFF, 16'h8000, "R6");

        // R9: idle cycles with moving operands keep the product
        step(1'b0, 1'b1, 16'h0123, 16'h4567, "R1");
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b0, 16'($urandom), 16'($urandom), "R9");
        end

        // R1: random traffic with random gaps
        for (int i = 0; i < 2000; i++) begin
            step(1'b0, ($urandom % 4) != 0, 16'($urandom), 16'($urandom), "R1");
        end

        // R8: reset while valid is presented
        step(1'b0, 1'b1, 16'h4000, 16'h7000, "R1");
        step(1'b1, 1'b1, 16'h2222, 16'h3333, "R8");
        step(1'b0, 1'b0, 16'h5555, 16'h6666, "R9");
        step(1'b0, 1'b0, 16'h0000, 16'h0000, "R9");

        @(negedge clk);
        check_out();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule